// File: doc/BRIEF.md
# Clock Output Stop and Enable Gating

This block sits between a clock generator and its output pads. It receives already generated source clocks for six domains: CPU, IOAPIC, PCI, SDRAM, a 48 MHz clock and a 24 MHz clock. From these it produces the final output clocks: two CPU outputs, one IOAPIC output, six PCI outputs, thirteen SDRAM outputs, one 48 MHz output and one 24 MHz output. Each output is either toggling or parked at logic 0. Three things decide this: a set of per-output and per-group enable bits, and two asynchronous active-low stop inputs. The CPU stop input acts on the CPU, IOAPIC and SDRAM group. The PCI stop input acts on the PCI group, and only in mobile mode. Some members of each group run free and are never stopped.

Every stop, enable and release passes through a synchronizer clocked by the source clock of that output. The gate may change only while the source clock is low. As a result, an output never emits a shortened high pulse. When an output is released, it resumes on a full cycle that starts with a rising edge. One global bit requests high impedance on all outputs. Because the pad drivers are outside this block, that request leaves the block as a single drive-enable signal.

Top module: `clkgate_top`

## Requirements
- R1: While `cpu_stop_n` is 0, `cpu1_o`, `apic_o` and `sdram_o[11:0]` stay at 0.
- R2: `cpu_free_o` and `sdram_o[12]` ignore `cpu_stop_n`. They toggle whenever their own enable bit (`en_cpu_free`, `en_sdram12`) is 1.
- R3: While `pci_stop_n` is 0 and `mode_desktop` is 0, `pci_o[4:0]` stay at 0. `pci_free_o` keeps toggling when `en_pci_free` is 1.
- R4: While `mode_desktop` is 1, `pci_stop_n` has no effect on any output.
- R5: An enable bit at 0 parks its outputs at 0. The mapping is: `en_sdram_grp[g]` covers `sdram_o[4g+3:4g]` for g = 0..2; `en_pci[i]` covers `pci_o[i]`; `en_cpu1`, `en_cpu_free`, `en_pci_free`, `en_sdram12`, `en_48` and `en_24` each cover one output of the same name. `apic_o` has no enable bit.
- R6: Suppose a change that stops an output is first sampled at source rising edge n. Then the high phase starting at edge n+1 is still complete, and from edge n+2 onward the output stays at 0 (SYNC_STAGES = 2).
- R7: Suppose a release is first sampled at source rising edge n. Then the output stays at 0 through the high phase of edge n+1, and its first pulse is a full high phase starting exactly at edge n+2.
- R8: Every high pulse on any output starts at a source rising edge and lasts a full source high phase. No runt pulse is ever produced.
- R9: `pad_oe` is 0 while `hiz_all` is 1 and 1 while `hiz_all` is 0.
- R10: While `rst_n` is 0, all clock outputs are 0. After release, the first pulse of every active output starts at the third source rising edge following the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_src | input | 1 | CPU domain source clock |
| clk_apic_src | input | 1 | IOAPIC domain source clock |
| clk_pci_src | input | 1 | PCI domain source clock |
| clk_sdram_src | input | 1 | SDRAM domain source clock |
| clk_48_src | input | 1 | 48 MHz source clock |
| clk_24_src | input | 1 | 24 MHz source clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every domain |
| cpu_stop_n | input | 1 | Asynchronous CPU-group stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-group stop, active low, used only in mobile mode |
| mode_desktop | input | 1 | 1 = desktop (PCI stop ignored), 0 = mobile |
| en_cpu_free | input | 1 | Enable for free-running CPU output |
| en_cpu1 | input | 1 | Enable for stoppable CPU output |
| en_pci_free | input | 1 | Enable for free-running PCI output |
| en_pci | input | 5 | Enables for PCI outputs 0..4 |
| en_sdram_grp | input | 3 | Enables for SDRAM groups of four |
| en_sdram12 | input | 1 | Enable for free-running SDRAM output 12 |
| en_48 | input | 1 | Enable for 48 MHz output |
| en_24 | input | 1 | Enable for 24 MHz output |
| hiz_all | input | 1 | Global high-impedance request |
| cpu_free_o | output | 1 | Free-running CPU clock |
| cpu1_o | output | 1 | Stoppable CPU clock |
| apic_o | output | 1 | IOAPIC clock |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_o | output | 5 | Stoppable PCI clocks |
| sdram_o | output | 13 | SDRAM clocks; bit 12 free-running |
| clk48_o | output | 1 | 48 MHz clock |
| clk24_o | output | 1 | 24 MHz clock |
| pad_oe | output | 1 | Pad drive enable, 0 requests high impedance |

## Verification
A wrong gate state shows up at the ports as a clock that is missing or present in the wrong high phase. It is seen no later than the second rising source edge after the cause was sampled, since the synchronizer fixes that latency exactly. A gate flop updated on the wrong clock phase shows up as a shortened high pulse. The bench catches this on the pulse itself by measuring each width against the source high phase. A wrong group mapping parks or frees the wrong output. A sweep over every stop and mode combination, crossed with walking-zero enable patterns, exposes it on the first sampled cycle.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
// Package: shared counts for the clock output gating block.
// Assumes the SDRAM stoppable outputs divide evenly into enable groups.
package clkgate_pkg;
    localparam int NUM_PCI      = 5;
    localparam int NUM_SDRAM    = 13;
    localparam int SD_GATED     = NUM_SDRAM - 1;
    localparam int SD_GRP_SIZE  = 4;
    localparam int NUM_SD_GRP   = SD_GATED / SD_GRP_SIZE;
    localparam int NUM_CPU      = 2;
    localparam int SYNC_DEFAULT = 2;
endpackage

// File: rtl/clkgate_allow_map.sv
`timescale 1ns/1ps
// Module: clkgate_allow_map
// Combines the stop inputs, mode and enable bits into one asynchronous
// "allow" level per output. Allow levels are still asynchronous here;
// each gating cell synchronizes its own level into its clock domain.
module clkgate_allow_map
    import clkgate_pkg::*;
(
    input  logic                  rst_n,
    input  logic                  cpu_stop_n,
    input  logic                  pci_stop_n,
    input  logic                  mode_desktop,
    input  logic                  en_cpu_free,
    input  logic                  en_cpu1,
    input  logic                  en_pci_free,
    input  logic [NUM_PCI-1:0]    en_pci,
    input  logic [NUM_SD_GRP-1:0] en_sdram_grp,
    input  logic                  en_sdram12,
    input  logic                  en_48,
    input  logic                  en_24,
    output logic [NUM_CPU-1:0]    cpu_allow,
    output logic                  apic_allow,
    output logic [NUM_PCI:0]      pci_allow,
    output logic [NUM_SDRAM-1:0]  sd_allow,
    output logic                  allow_48,
    output logic                  allow_24
);
    logic cpu_run;
    logic pci_hold;

    // CPU group runs unless its stop is asserted
    assign cpu_run  = cpu_stop_n;
    // PCI stop is honoured only in mobile mode
    assign pci_hold = ~pci_stop_n & ~mode_desktop;

    // CPU outputs: bit 0 free-running, bit 1 stoppable
    assign cpu_allow[0] = en_cpu_free;
    assign cpu_allow[1] = en_cpu1 & cpu_run;
    // IOAPIC has no enable bit, only the CPU stop
    assign apic_allow   = cpu_run;

    // PCI outputs: bit 0 free-running, bits 1..NUM_PCI stoppable
    assign pci_allow[0] = en_pci_free;
    genvar p;
    generate
        for (p = 0; p < NUM_PCI; p++) begin : g_pci
            assign pci_allow[p+1] = en_pci[p] & ~pci_hold;
        end
    endgenerate

    // SDRAM outputs: grouped enables, last output free-running
    genvar g, k;
    generate
        for (g = 0; g < NUM_SD_GRP; g++) begin : g_sdgrp
            for (k = 0; k < SD_GRP_SIZE; k++) begin : g_member
                assign sd_allow[g*SD_GRP_SIZE + k] = en_sdram_grp[g] & cpu_run;
            end
        end
    endgenerate
    assign sd_allow[NUM_SDRAM-1] = en_sdram12;

    // Fixed-frequency outputs follow their own enables only
    assign allow_48 = en_48;
    assign allow_24 = en_24;

    // Spec-level checks of the map against the top-level controls
    always_comb begin
        if (rst_n && !cpu_stop_n) begin
            assert_cpu_stop_R1: assert (sd_allow[SD_GATED-1:0] == '0 && !cpu_allow[1] && !apic_allow);
        end
        if (rst_n && en_cpu_free && en_sdram12) begin
            assert_free_members_R2: assert (cpu_allow[0] && sd_allow[NUM_SDRAM-1]);
        end
        if (rst_n && !pci_stop_n && !mode_desktop) begin
            assert_pci_stop_R3: assert (pci_allow[NUM_PCI:1] == '0);
        end
        if (rst_n && mode_desktop && (&en_pci)) begin
            assert_desktop_no_stop_R4: assert (&pci_allow[NUM_PCI:1]);
        end
    end
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
// Module: clkgate_cell
// One glitch-free clock gate. The asynchronous allow level is synchronized
// on rising edges, then moved into the gate flop on falling edges, so the
// gate only changes while the source clock is low. Output = clock AND gate.
// Assumes SYNC_STAGES >= 2.
module clkgate_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic allow_async,
    output logic clk_gated
);
    localparam int RUN_W = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   gate_q;
    logic [RUN_W-1:0]       on_run;
    logic [RUN_W-1:0]       off_run;

    // Synchronize the allow level into this clock domain
    always_ff @(posedge clk_src) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], allow_async};
    end

    // Update the gate only on the falling edge, while the clock is low
    always_ff @(negedge clk_src) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= sync_q[SYNC_STAGES-1];
    end

    // AND gate: a low gate parks the output at 0
    assign clk_gated = clk_src & gate_q;

    // Checker counters: consecutive rising edges with allow high / low
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            on_run  <= '0;
            off_run <= '0;
        end else if (allow_async) begin
            on_run  <= (on_run == RUN_SAT) ? on_run : on_run + RUN_W'(1);
            off_run <= '0;
        end else begin
            off_run <= (off_run == RUN_SAT) ? off_run : off_run + RUN_W'(1);
            on_run  <= '0;
        end
    end

    assert_parked_after_sync_R6: assert property (@(posedge clk_src) disable iff (!rst_n)
        (off_run == RUN_SAT) |-> !gate_q);

    assert_resumed_after_sync_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        (on_run == RUN_SAT) |-> gate_q);
endmodule

// File: rtl/clkgate_bank.sv
`timescale 1ns/1ps
// Module: clkgate_bank
// A row of NUM_OUT gating cells sharing one source clock and reset.
// Assumes every allow bit may change at any time relative to clk_src.
module clkgate_bank #(
    parameter int NUM_OUT     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] allow_async,
    output logic [NUM_OUT-1:0] clk_gated
);
    // One gating cell per output of this domain
    genvar i;
    generate
        for (i = 0; i < NUM_OUT; i++) begin : g_cell
            clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
                .clk_src     (clk_src),
                .rst_n       (rst_n),
                .allow_async (allow_async[i]),
                .clk_gated   (clk_gated[i])
            );
        end
    endgenerate
endmodule

// File: rtl/clkgate_top.sv
`timescale 1ns/1ps
// Module: clkgate_top
// Gates the generated output clocks of six domains by stop inputs and
// enable bits, and passes the global high-impedance request to the pads.
// Assumes rst_n is held low for at least SYNC_STAGES+1 cycles of every
// source clock.
module clkgate_top
    import clkgate_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEFAULT
) (
    input  logic                  clk_cpu_src,
    input  logic                  clk_apic_src,
    input  logic                  clk_pci_src,
    input  logic                  clk_sdram_src,
    input  logic                  clk_48_src,
    input  logic                  clk_24_src,
    input  logic                  rst_n,
    input  logic                  cpu_stop_n,
    input  logic                  pci_stop_n,
    input  logic                  mode_desktop,
    input  logic                  en_cpu_free,
    input  logic                  en_cpu1,
    input  logic                  en_pci_free,
    input  logic [NUM_PCI-1:0]    en_pci,
    input  logic [NUM_SD_GRP-1:0] en_sdram_grp,
    input  logic                  en_sdram12,
    input  logic                  en_48,
    input  logic                  en_24,
    input  logic                  hiz_all,
    output logic                  cpu_free_o,
    output logic                  cpu1_o,
    output logic                  apic_o,
    output logic                  pci_free_o,
    output logic [NUM_PCI-1:0]    pci_o,
    output logic [NUM_SDRAM-1:0]  sdram_o,
    output logic                  clk48_o,
    output logic                  clk24_o,
    output logic                  pad_oe
);
    logic [NUM_CPU-1:0]   cpu_allow;
    logic                 apic_allow;
    logic [NUM_PCI:0]     pci_allow;
    logic [NUM_SDRAM-1:0] sd_allow;
    logic                 allow_48;
    logic                 allow_24;
    logic [NUM_CPU-1:0]   cpu_gated;
    logic [NUM_PCI:0]     pci_gated;

    // Map stops, mode and enables to per-output allow levels
    clkgate_allow_map u_map (
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .mode_desktop (mode_desktop),
        .en_cpu_free  (en_cpu_free),
        .en_cpu1      (en_cpu1),
        .en_pci_free  (en_pci_free),
        .en_pci       (en_pci),
        .en_sdram_grp (en_sdram_grp),
        .en_sdram12   (en_sdram12),
        .en_48        (en_48),
        .en_24        (en_24),
        .cpu_allow    (cpu_allow),
        .apic_allow   (apic_allow),
        .pci_allow    (pci_allow),
        .sd_allow     (sd_allow),
        .allow_48     (allow_48),
        .allow_24     (allow_24)
    );

    // CPU domain gates
    clkgate_bank #(.NUM_OUT(NUM_CPU), .SYNC_STAGES(SYNC_STAGES)) u_cpu (
        .clk_src (clk_cpu_src), .rst_n (rst_n),
        .allow_async (cpu_allow), .clk_gated (cpu_gated)
    );

    // IOAPIC domain gate
    clkgate_bank #(.NUM_OUT(1), .SYNC_STAGES(SYNC_STAGES)) u_apic (
        .clk_src (clk_apic_src), .rst_n (rst_n),
        .allow_async (apic_allow), .clk_gated (apic_o)
    );

    // PCI domain gates
    clkgate_bank #(.NUM_OUT(NUM_PCI + 1), .SYNC_STAGES(SYNC_STAGES)) u_pci (
        .clk_src (clk_pci_src), .rst_n (rst_n),
        .allow_async (pci_allow), .clk_gated (pci_gated)
    );

    // SDRAM domain gates
    clkgate_bank #(.NUM_OUT(NUM_SDRAM), .SYNC_STAGES(SYNC_STAGES)) u_sdram (
        .clk_src (clk_sdram_src), .rst_n (rst_n),
        .allow_async (sd_allow), .clk_gated (sdram_o)
    );

    // 48 MHz domain gate
    clkgate_bank #(.NUM_OUT(1), .SYNC_STAGES(SYNC_STAGES)) u_48 (
        .clk_src (clk_48_src), .rst_n (rst_n),
        .allow_async (allow_48), .clk_gated (clk48_o)
    );

    // 24 MHz domain gate
    clkgate_bank #(.NUM_OUT(1), .SYNC_STAGES(SYNC_STAGES)) u_24 (
        .clk_src (clk_24_src), .rst_n (rst_n),
        .allow_async (allow_24), .clk_gated (clk24_o)
    );

    // Unpack the banked CPU and PCI outputs onto named ports
    assign cpu_free_o = cpu_gated[0];
    assign cpu1_o     = cpu_gated[1];
    assign pci_free_o = pci_gated[0];
    assign pci_o      = pci_gated[NUM_PCI:1];

    // Global high-impedance request drives the pad enable low
    assign pad_oe = ~hiz_all;
endmodule

// File: tb/clkgate_top_tb.sv
`timescale 1ns/1ps
module clkgate_top_tb;
    logic clk = 1'b0;
    logic rst_n, cpu_stop_n, pci_stop_n, mode_desktop, hiz_all;
    logic [13:0] en;
    logic cpu_free_o, cpu1_o, apic_o, pci_free_o, clk48_o, clk24_o, pad_oe;
    logic [4:0] pci_o;
    logic [12:0] sdram_o;
    logic [23:0] obs;
    int total = 0;
    int bad = 0;
    int runt_bad = 0;
    int rises = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkgate_top u_dut (
        .clk_cpu_src (clk), .clk_apic_src (clk), .clk_pci_src (clk),
        .clk_sdram_src (clk), .clk_48_src (clk), .clk_24_src (clk),
        .rst_n (rst_n), .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n),
        .mode_desktop (mode_desktop),
        .en_cpu_free (en[0]), .en_cpu1 (en[1]), .en_pci_free (en[2]),
        .en_pci (en[7:3]), .en_sdram_grp (en[10:8]), .en_sdram12 (en[11]),
        .en_48 (en[12]), .en_24 (en[13]), .hiz_all (hiz_all),
        .cpu_free_o (cpu_free_o), .cpu1_o (cpu1_o), .apic_o (apic_o),
        .pci_free_o (pci_free_o), .pci_o (pci_o), .sdram_o (sdram_o),
        .clk48_o (clk48_o), .clk24_o (clk24_o), .pad_oe (pad_oe)
    );

    assign obs = {clk24_o, clk48_o, sdram_o, pci_o, pci_free_o, apic_o, cpu1_o, cpu_free_o};

    // Pulse monitor for R8: rises on source edges, full 4 ns high phases
    real t_rise [24];
    logic [23:0] prev = '0;
    always @(obs) begin
        for (int i = 0; i < 24; i++) begin
            if (obs[i] === 1'b1 && prev[i] !== 1'b1) begin
                rises++;
                if (clk !== 1'b1) runt_bad++;
                t_rise[i] = $realtime;
            end else if (obs[i] === 1'b0 && prev[i] === 1'b1) begin
                if (($realtime - t_rise[i]) < 3.999 || ($realtime - t_rise[i]) > 4.001) runt_bad++;
            end
        end
        prev = obs;
    end

    function automatic logic [23:0] expect_run(logic cs_n, logic ps_n, logic md, logic [13:0] e);
        logic [23:0] r;
        logic cs, ps;
        cs = ~cs_n;
        ps = ~ps_n & ~md;
        r[0] = e[0];
        r[1] = e[1] & ~cs;
        r[2] = ~cs;
        r[3] = e[2];
        for (int i = 0; i < 5; i++) r[4+i] = e[3+i] & ~ps;
        for (int j = 0; j < 12; j++) r[9+j] = e[8 + j/4] & ~cs;
        r[21] = e[11];
        r[22] = e[12];
        r[23] = e[13];
        return r;
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sample in the middle of the next high phase
    task automatic sample_hi(output logic [23:0] v);
        @(posedge clk); #2; v = obs;
    endtask

    task automatic drive_slot();
        @(posedge clk); #3;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [23:0] vl;
        logic [23:0] all_on;
        rst_n = 0; cpu_stop_n = 1; pci_stop_n = 1; mode_desktop = 0; hiz_all = 0;
        en = '1;
        all_on = expect_run(1'b1, 1'b1, 1'b0, '1);
        repeat (3) sample_hi(v);
        check("R10 outputs low in reset", v, '0);

        // Reset release: first pulse at the third rising edge after release
        drive_slot(); rst_n = 1;
        sample_hi(v); check("R10 release edge 1", v, '0);
        sample_hi(v); check("R10 release edge 2", v, '0);
        sample_hi(v); check("R10 release edge 3", v, all_on);

        // R6: stop timing on cpu1_o and the CPU group
        drive_slot(); cpu_stop_n = 0;
        sample_hi(v); check("R6 stop edge n", v, all_on);
        sample_hi(v); check("R6 stop edge n+1", v, all_on);
        sample_hi(v); check("R6 stop edge n+2 R1", v, expect_run(1'b0, 1'b1, 1'b0, '1));
        // R7: release timing
        drive_slot(); cpu_stop_n = 1;
        sample_hi(v); check("R7 release edge n", v & 24'h1ffe06, 24'h0);
        sample_hi(v); check("R7 release edge n+1", v & 24'h1ffe06, 24'h0);
        sample_hi(v); check("R7 release edge n+2", v, all_on);

        // R3 / R4: PCI stop timing in both modes
        drive_slot(); pci_stop_n = 0;
        repeat (2) sample_hi(v);
        sample_hi(v); check("R3 pci stop mobile", v, expect_run(1'b1, 1'b0, 1'b0, '1));
        drive_slot(); mode_desktop = 1;
        repeat (2) sample_hi(v);
        sample_hi(v); check("R4 pci stop ignored desktop", v, all_on);
        drive_slot(); pci_stop_n = 1; mode_desktop = 0;
        repeat (3) sample_hi(v);

        // Sweep: stops x mode x walking-zero enables (R1 R2 R3 R4 R5)
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic [13:0] e;
                logic [23:0] ex;
                if (pat == 0) e = '1;
                else if (pat == 15) e = '0;
                else e = ~(14'd1 << (pat - 1));
                drive_slot();
                cpu_stop_n = cfg[0]; pci_stop_n = cfg[1]; mode_desktop = cfg[2]; en = e;
                ex = expect_run(cfg[0], cfg[1], cfg[2], e);
                repeat (3) sample_hi(v);
                #4; vl = obs;
                check("sweep R1 R2 R3 R4 R5 high phase", v, ex);
                check("sweep R5 low phase", vl, '0);
            end
        end

        // R9: high-impedance request
        hiz_all = 1; #1;
        check("R9 hiz set", {23'd0, pad_oe}, 24'd0);
        hiz_all = 0; #1;
        check("R9 hiz clear", {23'd0, pad_oe}, 24'd1);

        // R8: no runt pulses seen, and pulses were seen at all
        check("R8 runt pulses", 24'(runt_bad), 24'd0);
        check("R8 pulses observed", {23'd0, (rises > 100)}, 24'd1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule